// File: doc/BRIEF.md
# Card Data Frame Receiver

This block takes a data frame from a memory card over a one-bit data line and turns it into bytes plus per-frame status. Each bit on the line is sampled on one rising edge of the card clock `clk_i`. Software or a command unit sets the direction control to receive and pulses `arm_i`. The block then waits for the card's start bit, shifts in the payload and delivers it one byte at a time with a one-cycle strobe. It then checks the trailer and leaves sticky status flags.

There are two frame shapes. In block mode the payload is followed by a 16-bit CRC and an end bit. In stream mode the end bit follows the payload directly, and the CRC result stays clear. A card may be absent or silent, so the wait for the start bit is bounded by a programmable number of cycles. When that limit runs out, the block gives up and sets a time-out flag instead of hanging.

Top module: `card_rx_frame`

## Requirements
- R1: After reset the block is idle. `busy_o`, `byte_vld_o`, `eof_o`, `fmt_ok_o`, `crc_ok_o` and `timeout_o` are all 0.
- R2: An `arm_i` pulse starts a reception only when `dir_tx_i` is 0 and the block is idle. With `dir_tx_i` at 1, an arm is ignored and the flags keep their values. Raising `dir_tx_i` during a reception returns the block to idle on the next edge, with no end-of-frame and no further bytes.
- R3: While waiting, the first 0 sampled on `sd_i` is the start bit. Counting from the first sample after the arm edge, a start bit in any of the first `timeout_i` samples is accepted, and that includes the last one.
- R4: If none of those `timeout_i` samples is 0, the block sets `timeout_o` and returns to idle. `eof_o` stays 0.
- R5: The payload is exactly `blk_len_i` bytes (1 or more) in both modes, each assembled MSB first. Each byte appears on `byte_o` with `byte_vld_o` high for exactly one cycle.
- R6: In block mode, 16 CRC bits follow the payload MSB first. The CRC is x^16+x^12+x^5+1 (0x1021) with a zero start value, taken over the payload bits only. `crc_ok_o` is 1 exactly when all 16 received bits match.
- R7: In stream mode the end bit follows the last payload bit directly, and `crc_ok_o` is 0 after the frame.
- R8: One cycle after the end bit is sampled, `eof_o` is 1 and the block is idle. `fmt_ok_o` is 1 exactly when the end bit was 1.
- R9: The status flags hold until the next accepted arm. That arm clears all four flags on the same edge at which `busy_o` rises.
- R10: Mode, block length and time-out are captured at the accepted arm. Changing those inputs during a reception has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock; `sd_i` sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | 1 = transmit direction, receiver held idle |
| arm_i | input | 1 | Pulse to start a reception |
| stream_mode_i | input | 1 | 1 = stream frame, 0 = block frame |
| blk_len_i | input | LEN_W | Payload length in bytes |
| timeout_i | input | TO_W | Start-bit wait limit in samples |
| sd_i | input | 1 | Serial data line from card |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| busy_o | output | 1 | Reception in progress |
| eof_o | output | 1 | Sticky end-of-frame flag |
| fmt_ok_o | output | 1 | End bit was valid (1) |
| crc_ok_o | output | 1 | Block CRC matched; 0 in stream mode |
| timeout_o | output | 1 | Sticky start-bit time-out flag |

## Verification
Several properties are checked on every cycle. The byte strobe never lasts two cycles and is only seen while busy. An accepted arm clears every flag. A time-out never comes with end-of-frame, and end-of-frame in stream mode never carries a CRC pass. Setting the transmit direction always drops `busy_o` by the next edge. Only the bench's scenarios can show the rest: the byte values and their count, agreement with an independently computed CRC, and a corrupted CRC or a 0 end bit being reported. They also cover acceptance of a start bit on the last allowed sample, time-out one sample later, and immunity to configuration changes made mid-frame.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rx_state_e;

  // one serial step of an MSB-first CRC, zero feed on the low end
  function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                             input logic        din,
                                             input logic [15:0] poly);
    logic fb;
    fb = crc[15] ^ din;
    crc16_step = {crc[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction

endpackage

// File: rtl/card_rx_crc16.sv
module card_rx_crc16
  import card_rx_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic chk_i,
  input  logic bit_i,
  output logic err_o
);

  logic [15:0] crc_q;
  logic        err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
      err_q <= 1'b0;
    end else if (clr_i) begin
      crc_q <= '0;
      err_q <= 1'b0;
    end else if (upd_i) begin
      crc_q <= crc16_step(crc_q, bit_i, POLY);
    end else if (chk_i) begin
      // compare received trailer against remainder, MSB first
      err_q <= err_q | (bit_i ^ crc_q[15]);
      crc_q <= {crc_q[14:0], 1'b0};
    end
  end

  assign err_o = err_q;

  a_r6_no_upd_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && chk_i));

endmodule

// File: rtl/card_rx_deser.sv
module card_rx_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              last_bit_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] byte_q;
  logic              vld_q;

  assign last_bit_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (shift_i) begin
        sr_q <= {sr_q[BYTE_W-3:0], bit_i};
        if (last_bit_o) begin
          byte_q <= {sr_q, bit_i};
          vld_q  <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign byte_o = byte_q;
  assign vld_o  = vld_q;

  a_r5_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

endmodule

// File: rtl/card_rx_ctrl.sv
module card_rx_ctrl
  import card_rx_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int TO_W  = 16,
  parameter int CRC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_tx_i,
  input  logic             arm_i,
  input  logic             stream_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             sd_i,
  input  logic             byte_last_i,
  input  logic             crc_err_i,
  output logic             clr_o,
  output logic             shift_o,
  output logic             chk_o,
  output logic             busy_o,
  output logic             eof_o,
  output logic             fmt_ok_o,
  output logic             crc_ok_o,
  output logic             timeout_o
);

  localparam int CC_W = $clog2(CRC_W);
  localparam logic [CC_W-1:0] CC_LAST = CC_W'(CRC_W - 1);

  rx_state_e        state_q;
  logic             stream_q;
  logic [LEN_W-1:0] len_q;
  logic [TO_W-1:0]  tmo_q;
  logic [TO_W-1:0]  to_cnt_q;
  logic [TO_W:0]    to_nxt;
  logic [LEN_W-1:0] byte_cnt_q;
  logic [CC_W-1:0]  crc_cnt_q;
  logic             eof_q, fmt_q, crc_ok_q, tmo_flag_q;
  logic             last_byte;

  assign to_nxt    = {1'b0, to_cnt_q} + {{TO_W{1'b0}}, 1'b1};
  assign last_byte = (byte_cnt_q == len_q - LEN_W'(1));

  always_comb begin
    clr_o   = arm_i && !dir_tx_i && (state_q == ST_IDLE);
    shift_o = (state_q == ST_DATA) && !dir_tx_i;
    chk_o   = (state_q == ST_CRC) && !dir_tx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      stream_q   <= 1'b0;
      len_q      <= '0;
      tmo_q      <= '0;
      to_cnt_q   <= '0;
      byte_cnt_q <= '0;
      crc_cnt_q  <= '0;
      eof_q      <= 1'b0;
      fmt_q      <= 1'b0;
      crc_ok_q   <= 1'b0;
      tmo_flag_q <= 1'b0;
    end else if (dir_tx_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          state_q    <= ST_WAIT;
          stream_q   <= stream_i;
          len_q      <= len_i;
          tmo_q      <= timeout_i;
          to_cnt_q   <= '0;
          eof_q      <= 1'b0;
          fmt_q      <= 1'b0;
          crc_ok_q   <= 1'b0;
          tmo_flag_q <= 1'b0;
        end
        ST_WAIT: begin
          if (!sd_i) begin
            state_q    <= ST_DATA;
            byte_cnt_q <= '0;
          end else if (to_nxt >= {1'b0, tmo_q}) begin
            tmo_flag_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            to_cnt_q <= to_nxt[TO_W-1:0];
          end
        end
        ST_DATA: if (byte_last_i) begin
          if (last_byte) begin
            state_q   <= stream_q ? ST_END : ST_CRC;
            crc_cnt_q <= '0;
          end else begin
            byte_cnt_q <= byte_cnt_q + LEN_W'(1);
          end
        end
        ST_CRC: begin
          if (crc_cnt_q == CC_LAST) state_q <= ST_END;
          else crc_cnt_q <= crc_cnt_q + CC_W'(1);
        end
        ST_END: begin
          eof_q    <= 1'b1;
          fmt_q    <= sd_i;
          crc_ok_q <= !stream_q && !crc_err_i;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign eof_o     = eof_q;
  assign fmt_ok_o  = fmt_q;
  assign crc_ok_o  = crc_ok_q;
  assign timeout_o = tmo_flag_q;

  a_r2_dir_tx_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_i |=> !busy_o);
  a_r4_timeout_no_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!eof_o && !busy_o));
  a_r7_stream_crc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eof_o) && stream_q) |-> !crc_ok_o);
  a_r8_eof_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eof_o) |-> !busy_o);
  a_r9_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!eof_o && !fmt_ok_o && !crc_ok_o && !timeout_o));

endmodule

// File: rtl/card_rx_frame.sv
module card_rx_frame #(
  parameter int          LEN_W  = 10,
  parameter int          TO_W   = 16,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_tx_i,
  input  logic             arm_i,
  input  logic             stream_mode_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic             sd_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             busy_o,
  output logic             eof_o,
  output logic             fmt_ok_o,
  output logic             crc_ok_o,
  output logic             timeout_o
);

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  logic clr, shift, chk, byte_last, crc_err;

  card_rx_ctrl #(
    .LEN_W(LEN_W),
    .TO_W (TO_W),
    .CRC_W(CRC_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_tx_i   (dir_tx_i),
    .arm_i      (arm_i),
    .stream_i   (stream_mode_i),
    .len_i      (blk_len_i),
    .timeout_i  (timeout_i),
    .sd_i       (sd_i),
    .byte_last_i(byte_last),
    .crc_err_i  (crc_err),
    .clr_o      (clr),
    .shift_o    (shift),
    .chk_o      (chk),
    .busy_o     (busy_o),
    .eof_o      (eof_o),
    .fmt_ok_o   (fmt_ok_o),
    .crc_ok_o   (crc_ok_o),
    .timeout_o  (timeout_o)
  );

  card_rx_deser #(.BYTE_W(BYTE_W)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .shift_i   (shift),
    .bit_i     (sd_i),
    .last_bit_o(byte_last),
    .byte_o    (byte_o),
    .vld_o     (byte_vld_o)
  );

  card_rx_crc16 #(.POLY(POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .upd_i (shift),
    .chk_i (chk),
    .bit_i (sd_i),
    .err_o (crc_err)
  );

  a_r5_vld_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> busy_o);

endmodule

// File: tb/card_rx_frame_tb_top.sv
`timescale 1ns/1ps
module card_rx_frame_tb_top;

  localparam int LEN_W = 10;
  localparam int TO_W  = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             dir_tx_i = 1'b0;
  logic             arm_i = 1'b0;
  logic             stream_mode_i = 1'b0;
  logic [LEN_W-1:0] blk_len_i = '0;
  logic [TO_W-1:0]  timeout_i = '0;
  logic             sd_i = 1'b1;
  logic [7:0]       byte_o;
  logic             byte_vld_o, busy_o, eof_o, fmt_ok_o, crc_ok_o, timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] got_q[$];

  always #2.5 clk_i = ~clk_i;

  card_rx_frame #(.LEN_W(LEN_W), .TO_W(TO_W)) dut_i (
    .clk_i, .rst_ni, .dir_tx_i, .arm_i, .stream_mode_i, .blk_len_i,
    .timeout_i, .sd_i, .byte_o, .byte_vld_o, .busy_o, .eof_o,
    .fmt_ok_o, .crc_ok_o, .timeout_o
  );

  always @(negedge clk_i) if (byte_vld_o) got_q.push_back(byte_o);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] pay[$]);
    logic [15:0] c = 16'h0;
    foreach (pay[i])
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ pay[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  // drive one line bit, return at the next falling edge
  task automatic line(input logic b);
    sd_i = b;
    @(negedge clk_i);
  endtask

  task automatic arm(input bit stream, input int len, input int tmo);
    stream_mode_i = stream;
    blk_len_i = LEN_W'(len);
    timeout_i = TO_W'(tmo);
    arm_i = 1'b1;
    sd_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    got_q.delete();
    // R10: scramble configuration after capture
    stream_mode_i = ~stream;
    blk_len_i = LEN_W'($urandom_range(1, 30));
    timeout_i = TO_W'($urandom_range(1, 3));
  endtask

  task automatic run_frame(input bit stream, input int len, input int dly,
                           input int extra, input bit bad_crc, input bit endb);
    logic [7:0] pay[$];
    logic [15:0] crc;
    int flip;
    for (int i = 0; i < len; i++) pay.push_back(8'($urandom));
    crc = ref_crc(pay);
    flip = $urandom_range(0, 15);
    arm(stream, len, dly + 1 + extra);
    check(busy_o && !eof_o && !timeout_o && !crc_ok_o && !fmt_ok_o, "R9",
          "flags cleared at arm", {busy_o, eof_o, timeout_o}, 3'b100);
    for (int i = 0; i < dly; i++) line(1'b1);
    line(1'b0);
    foreach (pay[i]) for (int b = 7; b >= 0; b--) line(pay[i][b]);
    if (!stream)
      for (int b = 15; b >= 0; b--) line(crc[b] ^ (bad_crc && b == flip));
    line(endb);
    sd_i = 1'b1;
    check(eof_o && !busy_o, "R8", "eof after end bit", {eof_o, busy_o}, 2'b10);
    check(fmt_ok_o == endb, "R8", "end bit status", fmt_ok_o, endb);
    if (stream) check(!crc_ok_o, "R7", "stream crc flag", crc_ok_o, 0);
    else check(crc_ok_o == !bad_crc, "R6", "crc status", crc_ok_o, !bad_crc);
    check(!timeout_o, "R3", "no time-out on start", timeout_o, 0);
    check(got_q.size() == len, "R5", "byte count", got_q.size(), len);
    if (got_q.size() == len)
      foreach (pay[i])
        if (got_q[i] != pay[i])
          check(0, "R5", "byte value", got_q[i], pay[i]);
    repeat ($urandom_range(0, 3)) @(negedge clk_i);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check({busy_o, byte_vld_o, eof_o, fmt_ok_o, crc_ok_o, timeout_o} == 6'b0,
          "R1", "reset outputs",
          {busy_o, byte_vld_o, eof_o, fmt_ok_o, crc_ok_o, timeout_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o, "R1", "idle after reset", busy_o, 0);

    // directed corners
    run_frame(1'b0, 1, 0, 0, 1'b0, 1'b1);   // R6 minimal block
    run_frame(1'b1, 1, 0, 0, 1'b0, 1'b1);   // R7 minimal stream
    run_frame(1'b0, 4, 5, 0, 1'b0, 1'b1);   // R3 start on last allowed sample
    run_frame(1'b0, 3, 2, 4, 1'b1, 1'b1);   // R6 corrupted crc
    run_frame(1'b0, 2, 1, 1, 1'b0, 1'b0);   // R8 bad end bit
    run_frame(1'b1, 5, 0, 2, 1'b0, 1'b0);   // R7/R8 stream, bad end bit

    // R4: time-out exactly after timeout_i samples
    arm(1'b0, 4, 6);
    repeat (5) line(1'b1);
    check(busy_o && !timeout_o, "R4", "still waiting", {busy_o, timeout_o}, 2'b10);
    line(1'b1);
    check(!busy_o && timeout_o && !eof_o, "R4", "time-out",
          {busy_o, timeout_o, eof_o}, 3'b010);

    // R2: arm in transmit direction ignored, flags kept
    dir_tx_i = 1'b1;
    arm_i = 1'b1;
    sd_i = 1'b0;
    @(negedge clk_i);
    arm_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!busy_o && timeout_o, "R2", "arm ignored in tx",
          {busy_o, timeout_o}, 2'b01);
    dir_tx_i = 1'b0;
    sd_i = 1'b1;
    @(negedge clk_i);

    // R2: abort mid-payload
    arm(1'b0, 6, 3);
    line(1'b0);
    repeat (12) line(1'($urandom));
    dir_tx_i = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !eof_o, "R2", "abort to idle", {busy_o, eof_o}, 2'b00);
    check(got_q.size() == 1, "R2", "bytes before abort", got_q.size(), 1);
    repeat (10) line(1'($urandom));
    check(got_q.size() == 1 && !eof_o, "R2", "no bytes after abort",
          got_q.size(), 1);
    dir_tx_i = 1'b0;
    sd_i = 1'b1;
    @(negedge clk_i);

    // random mix
    for (int n = 0; n < 40; n++)
      run_frame(1'($urandom), $urandom_range(1, 20), $urandom_range(0, 12),
                $urandom_range(0, 5), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 5) != 0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule